// File: doc/BRIEF.md
# Cascaded Interrupt Request Latch

This block captures interrupt-line events for a pair of cascaded 8-input interrupt controllers. Sixteen request lines are addressed by number: a raise strobe latches the request and a drop strobe withdraws it. Lines 0 to 7 belong to the primary controller. Lines 8 to 15 belong to the secondary controller. Every secondary request is also mirrored onto the primary controller's cascade input, which is input 2.

Each line has its own trigger-mode bit, 0 for edge and 1 for level. A drop strobe only has an effect on level lines. An edge request stays latched until the downstream priority resolver grants it and returns a clear mask.

The mode bits sit in two byte-wide registers behind a small bus port. A single-line mode setter sits beside that port. The block outputs both request vectors and one "asserted" flag per controller for the resolver to use.

Top module: `irq_req_latch`

## Requirements
- R1: A raise strobe on line n (0..7) sets primary request bit n and the primary asserted flag one clock later.
- R2: A raise strobe on line n (8..15) sets secondary bit n-8, the secondary asserted flag, primary bit 2 and the primary asserted flag one clock later.
- R3: A drop strobe clears the line's request bit only when its mode bit is 1 (level). With mode 0 (edge) the bit stays set until a grant clears it.
- R4: If a drop strobe on a secondary line leaves the secondary request vector at zero, primary bit 2 is cleared in the same update.
- R5: A grant clear mask clears the bits it marks. A controller's asserted flag drops when a non-zero grant mask leaves that controller's request vector empty. A raise on a bit wins over a grant clear of that bit in the same cycle.
- R6: Mode register index 0 holds the primary lines and index 1 holds the secondary lines, with bit k mapping to line k within its controller. Both registers reset to 0 and can be written. The read data combinationally reflects the register at `cfg_idx`.
- R7: The single-line mode setter ignores a line number above 15 or a value above 1. When it hits the register that a bus write targets in the same cycle, its bit is applied on top of the written byte.
- R8: A bus write with index 2 or 3 changes nothing. A read at index 2 or 3 returns 0xFF.
- R9: After reset both request vectors and both asserted flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_set_vld | input | 1 | Raise strobe |
| line_set_num | input | 4 | Line number for the raise strobe |
| line_clr_vld | input | 1 | Drop strobe |
| line_clr_num | input | 4 | Line number for the drop strobe |
| pri_grant_clr | input | 8 | Primary request bits to clear on grant |
| sec_grant_clr | input | 8 | Secondary request bits to clear on grant |
| cfg_wr | input | 1 | Mode register write enable |
| cfg_idx | input | 2 | Mode register index |
| cfg_wdata | input | 8 | Mode register write data |
| cfg_rdata | output | 8 | Mode register read data |
| mode_set_vld | input | 1 | Single-line mode set strobe |
| mode_set_line | input | 5 | Line number for the mode set |
| mode_set_val | input | 2 | Mode value (0 edge, 1 level) |
| pri_req | output | 8 | Primary request vector |
| sec_req | output | 8 | Secondary request vector |
| pri_asserted | output | 1 | Primary asserted flag |
| sec_asserted | output | 1 | Secondary asserted flag |

## Verification
Two pairs of events can land in the same cycle. The first is a raise and a grant clear on the same request bit. The bench provokes it by raising line 6 while granting primary bit 6, and again by raising a secondary line while granting primary bit 2. It expects the bit and the flag to come out set. The second is a bus write and a single-line mode set aimed at the same register. The bench writes 0xF0 to index 0 while setting line 0 to level, and expects to read back 0xF1.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  // one-hot byte lane for a 3-bit position
  function automatic logic [7:0] lane_onehot(input logic [2:0] pos);
    lane_onehot = 8'(1) << pos;
  endfunction

  // next request vector: drop marked bits, then apply new raises
  function automatic logic [7:0] req_update(input logic [7:0] cur,
                                            input logic [7:0] drop,
                                            input logic [7:0] raise);
    req_update = (cur & ~drop) | raise;
  endfunction
endpackage

// File: rtl/irq_mode_regs.sv
module irq_mode_regs #(
  parameter int LINES = 16,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_idx,
  input  logic [LINES/2-1:0] cfg_wdata,
  output logic [LINES/2-1:0] cfg_rdata,
  input  logic              mode_set_vld,
  input  logic [IDX_W:0]    mode_set_line,
  input  logic [1:0]        mode_set_val,
  output logic [LINES/2-1:0] pri_level,
  output logic [LINES/2-1:0] sec_level
);
  localparam int W = LINES / 2;

  logic [1:0][W-1:0] lvl_q, lvl_d;
  logic              wr_ok, mode_ok;

  assign wr_ok   = cfg_wr && (cfg_idx < 2'd2);
  assign mode_ok = mode_set_vld && (mode_set_line < (IDX_W+1)'(LINES)) && (mode_set_val < 2'd2);

  always_comb begin
    lvl_d = lvl_q;
    if (wr_ok) lvl_d[cfg_idx[0]] = cfg_wdata;
    if (mode_ok) lvl_d[mode_set_line[IDX_W-1]][mode_set_line[IDX_W-2:0]] = mode_set_val[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  assign cfg_rdata = (cfg_idx < 2'd2) ? lvl_q[cfg_idx[0]] : '1;
  assign pri_level = lvl_q[0];
  assign sec_level = lvl_q[1];

  AST_BAD_INDEX_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_idx[1] && !mode_set_vld) |=> $stable(lvl_q)); // R8
  AST_BAD_MODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_set_vld && !mode_ok && !cfg_wr) |=> $stable(lvl_q)); // R7
  always_comb begin
    if (cfg_idx[1]) AST_BAD_INDEX_READ: assert (cfg_rdata == '1); // R8
  end
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raise_mask,
  input  logic [W-1:0] level_drop,
  input  logic [W-1:0] grant_drop,
  output logic [W-1:0] req_q,
  output logic [W-1:0] req_nxt,
  output logic         flag_q
);
  import irq_latch_pkg::*;

  logic grant_empties;

  assign req_nxt       = req_update(req_q, level_drop | grant_drop, raise_mask);
  assign grant_empties = (|grant_drop) && (req_nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      req_q <= req_nxt;
      if (|raise_mask)        flag_q <= 1'b1;
      else if (grant_empties) flag_q <= 1'b0;
    end
  end

  AST_RAISE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((req_q & $past(raise_mask)) == $past(raise_mask))); // R5
  AST_HELD_UNTIL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(req_q) & ~$past(level_drop | grant_drop) & ~req_q) == '0)); // R3
  AST_FLAG_ON_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && |raise_mask) |=> flag_q); // R1
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int LINES     = 16,
  parameter int CASC_BIT  = 2,
  parameter int IDX_W     = $clog2(LINES),
  parameter int W         = LINES / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_set_vld,
  input  logic [IDX_W-1:0] line_set_num,
  input  logic             line_clr_vld,
  input  logic [IDX_W-1:0] line_clr_num,
  input  logic [W-1:0]     pri_grant_clr,
  input  logic [W-1:0]     sec_grant_clr,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_idx,
  input  logic [W-1:0]     cfg_wdata,
  output logic [W-1:0]     cfg_rdata,
  input  logic             mode_set_vld,
  input  logic [IDX_W:0]   mode_set_line,
  input  logic [1:0]       mode_set_val,
  output logic [W-1:0]     pri_req,
  output logic [W-1:0]     sec_req,
  output logic             pri_asserted,
  output logic             sec_asserted
);
  import irq_latch_pkg::*;

  localparam logic [W-1:0] CASC_MASK = W'(1) << CASC_BIT;

  logic [W-1:0] pri_level, sec_level;
  logic [W-1:0] pri_raise, sec_raise, pri_drop, sec_drop;
  logic [W-1:0] pri_nxt, sec_nxt;
  logic         set_on_sec, clr_on_sec, clr_is_level, sec_emptied;
  logic [W-1:0] set_lane, clr_lane;

  irq_mode_regs #(.LINES(LINES), .IDX_W(IDX_W)) u_modes (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mode_set_vld(mode_set_vld), .mode_set_line(mode_set_line), .mode_set_val(mode_set_val),
    .pri_level(pri_level), .sec_level(sec_level)
  );

  assign set_on_sec   = line_set_num[IDX_W-1];
  assign clr_on_sec   = line_clr_num[IDX_W-1];
  assign set_lane     = lane_onehot(line_set_num[IDX_W-2:0]);
  assign clr_lane     = lane_onehot(line_clr_num[IDX_W-2:0]);
  assign clr_is_level = line_clr_vld && (|((clr_on_sec ? sec_level : pri_level) & clr_lane));

  assign sec_raise   = (line_set_vld && set_on_sec) ? set_lane : '0;
  assign pri_raise   = line_set_vld ? (set_on_sec ? CASC_MASK : set_lane) : '0;
  assign sec_drop    = (clr_is_level && clr_on_sec) ? clr_lane : '0;
  assign sec_emptied = (clr_is_level && clr_on_sec) && (sec_nxt == '0);
  assign pri_drop    = ((clr_is_level && !clr_on_sec) ? clr_lane : '0)
                     | (sec_emptied ? CASC_MASK : '0);

  irq_req_bank #(.W(W)) u_sec_bank (
    .clk(clk), .rst_n(rst_n), .raise_mask(sec_raise), .level_drop(sec_drop),
    .grant_drop(sec_grant_clr), .req_q(sec_req), .req_nxt(sec_nxt), .flag_q(sec_asserted)
  );

  irq_req_bank #(.W(W)) u_pri_bank (
    .clk(clk), .rst_n(rst_n), .raise_mask(pri_raise), .level_drop(pri_drop),
    .grant_drop(pri_grant_clr), .req_q(pri_req), .req_nxt(pri_nxt), .flag_q(pri_asserted)
  );

  AST_SEC_MIRRORS_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && line_set_vld && set_on_sec) |=> (pri_req[CASC_BIT] && pri_asserted)); // R2
  AST_CASCADE_FOLLOWS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && sec_emptied && !line_set_vld) |=> (!pri_req[CASC_BIT] && sec_req == '0)); // R4
  AST_EDGE_DROP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && line_clr_vld && !clr_is_level && !line_set_vld && pri_grant_clr == '0 && sec_grant_clr == '0)
      |=> ($stable(pri_req) && $stable(sec_req))); // R3
endmodule

// File: tb/irq_req_latch_tb.sv
module irq_req_latch_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_set_vld = 1'b0, line_clr_vld = 1'b0;
  logic [3:0] line_set_num = '0, line_clr_num = '0;
  logic [7:0] pri_grant_clr = '0, sec_grant_clr = '0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_idx = '0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic       mode_set_vld = 1'b0;
  logic [4:0] mode_set_line = '0;
  logic [1:0] mode_set_val = '0;
  logic [7:0] pri_req, sec_req;
  logic       pri_asserted, sec_asserted;
  int n_checks = 0, n_fails = 0;

  always #5 clk = ~clk;

  irq_req_latch dut_i (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    line_set_vld = 0; line_clr_vld = 0; pri_grant_clr = '0; sec_grant_clr = '0;
    cfg_wr = 0; mode_set_vld = 0;
  endtask

  task automatic step();
    @(negedge clk); idle();
  endtask

  task automatic raise(input logic [3:0] n);
    line_set_vld = 1; line_set_num = n; step();
  endtask

  task automatic drop(input logic [3:0] n);
    line_clr_vld = 1; line_clr_num = n; step();
  endtask

  task automatic grant(input logic [7:0] p, input logic [7:0] s);
    pri_grant_clr = p; sec_grant_clr = s; step();
  endtask

  task automatic cfg_write(input logic [1:0] i, input logic [7:0] d);
    cfg_wr = 1; cfg_idx = i; cfg_wdata = d; step();
  endtask

  task automatic read_at(input logic [1:0] i, input string req, input logic [7:0] exp);
    cfg_idx = i; #1; chk(req, cfg_rdata, exp);
  endtask

  task automatic mode_set(input logic [4:0] l, input logic [1:0] v);
    mode_set_vld = 1; mode_set_line = l; mode_set_val = v; step();
  endtask

  task automatic t_reset();
    chk("R9 pri_req", pri_req, 8'h00);
    chk("R9 sec_req", sec_req, 8'h00);
    chk("R9 flags", {6'b0, pri_asserted, sec_asserted}, 8'h00);
    read_at(2'd0, "R6 reset idx0", 8'h00);
    read_at(2'd1, "R6 reset idx1", 8'h00);
  endtask

  task automatic t_primary();
    raise(4'd5);
    chk("R1 pri_req", pri_req, 8'h20);
    chk("R1 flags", {6'b0, pri_asserted, sec_asserted}, 8'h02);
    grant(8'h20, 8'h00);
    chk("R5 grant clear", pri_req, 8'h00);
    chk("R5 flag drop", {7'b0, pri_asserted}, 8'h00);
  endtask

  task automatic t_secondary();
    raise(4'd11);
    chk("R2 sec_req", sec_req, 8'h08);
    chk("R2 pri cascade", pri_req, 8'h04);
    chk("R2 flags", {6'b0, pri_asserted, sec_asserted}, 8'h03);
    grant(8'h04, 8'h08);
    chk("R5 both cleared", {pri_req | sec_req}, 8'h00);
    chk("R5 both flags", {6'b0, pri_asserted, sec_asserted}, 8'h00);
  endtask

  task automatic t_edge_and_level();
    raise(4'd3);
    drop(4'd3);
    chk("R3 edge held", pri_req, 8'h08);
    cfg_write(2'd0, 8'h08);
    read_at(2'd0, "R6 write idx0", 8'h08);
    drop(4'd3);
    chk("R3 level dropped", pri_req, 8'h00);
    grant(8'h08, 8'h00);
    chk("R5 flag after empty grant", {7'b0, pri_asserted}, 8'h00);
  endtask

  task automatic t_cascade_empty();
    cfg_write(2'd1, 8'h03);
    read_at(2'd1, "R6 write idx1", 8'h03);
    raise(4'd8);
    raise(4'd9);
    drop(4'd8);
    chk("R4 partial sec", sec_req, 8'h02);
    chk("R4 cascade kept", pri_req, 8'h04);
    drop(4'd9);
    chk("R4 sec empty", sec_req, 8'h00);
    chk("R4 cascade cleared", pri_req, 8'h00);
    grant(8'h04, 8'h01);
  endtask

  task automatic t_same_cycle();
    line_set_vld = 1; line_set_num = 4'd6; pri_grant_clr = 8'h40; step();
    chk("R5 raise wins", pri_req, 8'h40);
    chk("R5 flag kept", {7'b0, pri_asserted}, 8'h01);
    line_set_vld = 1; line_set_num = 4'd14; pri_grant_clr = 8'h44; step();
    chk("R5 cascade raise wins", pri_req, 8'h04);
    chk("R2 sec bit 6", sec_req, 8'h40);
    grant(8'h04, 8'h40);
  endtask

  task automatic t_mode_set();
    mode_set(5'd20, 2'd1);
    read_at(2'd1, "R7 line>15 ignored", 8'h03);
    mode_set(5'd4, 2'd2);
    read_at(2'd0, "R7 value>1 ignored", 8'h08);
    mode_set(5'd12, 2'd1);
    read_at(2'd1, "R7 sec line 12", 8'h13);
    mode_set(5'd3, 2'd0);
    read_at(2'd0, "R7 pri line 3 edge", 8'h00);
    cfg_wr = 1; cfg_idx = 2'd0; cfg_wdata = 8'hF0;
    mode_set_vld = 1; mode_set_line = 5'd0; mode_set_val = 2'd1; step();
    read_at(2'd0, "R7 merge with write", 8'hF1);
  endtask

  task automatic t_bad_index();
    cfg_write(2'd2, 8'h55);
    cfg_write(2'd3, 8'hAA);
    read_at(2'd0, "R8 idx0 untouched", 8'hF1);
    read_at(2'd1, "R8 idx1 untouched", 8'h13);
    read_at(2'd3, "R8 read idx3", 8'hFF);
    read_at(2'd2, "R8 read idx2", 8'hFF);
  endtask

  initial begin
    #2_000_000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_primary();
    t_secondary();
    t_edge_and_level();
    t_cascade_empty();
    t_same_cycle();
    t_mode_set();
    t_bad_index();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule